// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block holds the per-pin configuration of a 32-pin parallel I/O port. A synchronous register port reaches it. Almost every setting is a group of three registers: a write-one-to-set register, a write-one-to-clear register, and a read-only status register. In the two write registers a 0 bit leaves the setting unchanged. Output data has two extra ways in: a direct masked write, and a read of the live pad levels.

Each pin is owned either by the controller or by a peripheral function. When a peripheral owns the pin, a select bit picks function A or function B. The owner drives the pad output-enable and the pad data. Multi-drive turns a driver into open-drain. The block also drives an active-low pull-up control and a glitch-filter enable line for each pin.

Output-enable and data settings are kept while a peripheral owns a pin. They reach the pad again as soon as the controller takes the pin back.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pin is owned by the controller (status 0x08 reads all ones). Status registers 0x18, 0x28, 0x38, 0x58, 0x68, 0x78 and 0xA8 all read 0. `pad_oe` is 0 and `pad_pullup_n` is 0, so every pull-up is on.
- R2: In each pair of set/clear offsets, a write sets or clears exactly the status bits given as 1 in the write data, and the other bits keep their value. The pairs and their status offsets are:
  - ownership: set 0x00, clear 0x04, status 0x08
  - output-enable: set 0x10, clear 0x14, status 0x18
  - filter: set 0x20, clear 0x24, status 0x28
  - multi-drive: set 0x50, clear 0x54, status 0x58
  - output-write: set 0xA0, clear 0xA4, status 0xA8
- R3: A read (`bus_sel`=1, `bus_wr`=0) places its data on `bus_rdata` at the next rising clock edge. Write-only offsets and unmapped offsets read 0.
- R4: On a pin the controller owns, `pad_oe` follows the output-enable status bit and `pad_out` follows the data status bit. On such a pin, `pa_din` and `pb_din` are 0.
- R5: Writes to output-enable and to data (set 0x30, clear 0x34) are stored while a peripheral owns the pin, and they do not change the pad. They appear on the pad as soon as the controller owns the pin again.
- R6: A 1 written to 0x70 selects peripheral A on that pin, and a 1 written to 0x74 selects peripheral B. Status 0x78 reads 0 for A and 1 for B. The selected peripheral drives the pad on pins a peripheral owns, and only that peripheral's data input (`pa_din` or `pb_din`) gets the pad level; the other one reads 0.
- R7: A write to 0x38 loads data status bits only where the output-write status bit is 1. All other data bits keep their value.
- R8: Offset 0x3C reads the live `pad_in` levels, whatever the pin's ownership or direction.
- R9: A 1 written to 0x60 turns the pull-up off, and a 1 written to 0x64 turns it on. Status 0x68 reads 1 where the pull-up is off, and `pad_pullup_n` equals that status.
- R10: On a pin with multi-drive on, the pad is driven only while the driven data is 0, so `pad_oe` and `pad_out` are never both 1 on that pin.
- R11: `filt_en` equals the filter status bits; filter set is 0x20 and clear is 0x24 (R2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_sel | input | 1 | register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | byte offset |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, registered |
| pad_in | input | 32 | live pad levels |
| pad_oe | output | 32 | pad output-enable |
| pad_out | output | 32 | pad output data |
| pad_pullup_n | output | 32 | pull-up control, active low |
| filt_en | output | 32 | glitch filter enable per pin |
| pa_oe | input | 32 | peripheral A output-enable |
| pa_out | input | 32 | peripheral A output data |
| pa_din | output | 32 | pad level to peripheral A |
| pb_oe | input | 32 | peripheral B output-enable |
| pb_out | input | 32 | peripheral B output data |
| pb_din | output | 32 | pad level to peripheral B |

## Verification
The pin mux is tried with the low half owned by the controller and the high half owned by peripherals. In the high half, one byte is switched to peripheral B, each peripheral gets a distinct oe/data pattern, and the two drive different bytes. This separates an A/B mix-up and an ownership mix-up from a correct mux. Settings are written while a peripheral owns the pin, and the ownership is then handed back, which shows whether those settings were stored. Direct data writes are made with a partial output-write mask and then with an empty one. Multi-drive is applied to data that mixes ones and zeros, so that a plain output enable and an open-drain enable give different results.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PIN_W  = 32;
    localparam int ADDR_W = 8;

    typedef logic [PIN_W-1:0]  pins_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // set/clear/status triplets, index order fixed below
    localparam int N_TRIP = 7;
    typedef enum int {
        T_OWN = 0, T_OE = 1, T_FILT = 2, T_MD = 3,
        T_PUOFF = 4, T_SELB = 5, T_OWE = 6
    } trip_e;

    localparam addr_t OFF_DSET  = 8'h30;
    localparam addr_t OFF_DCLR  = 8'h34;
    localparam addr_t OFF_DSTAT = 8'h38;
    localparam addr_t OFF_PIN   = 8'h3C;

    typedef struct packed {
        pins_t own;
        pins_t oe;
        pins_t filt;
        pins_t md;
        pins_t pu_off;
        pins_t selb;
        pins_t owe;
        pins_t dout;
    } cfg_t;

    function automatic addr_t trip_set_off(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'h10;
            2: return 8'h20;
            3: return 8'h50;
            4: return 8'h60;
            5: return 8'h74;
            6: return 8'hA0;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic addr_t trip_clr_off(input int i);
        case (i)
            0: return 8'h04;
            1: return 8'h14;
            2: return 8'h24;
            3: return 8'h54;
            4: return 8'h64;
            5: return 8'h70;
            6: return 8'hA4;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic addr_t trip_stat_off(input int i);
        return trip_set_off(i) + 8'h08 - ((i == 5) ? 8'h04 : 8'h00);
    endfunction

    function automatic pins_t trip_rst(input int i);
        return (i == int'(T_OWN)) ? '1 : '0;
    endfunction
endpackage

// File: rtl/gpio_triplet.sv
module gpio_triplet #(
    parameter int             W       = 32,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         load_we,
    input  logic [W-1:0] load_mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (set_we)
            q <= q | wdata;
        else if (clr_we)
            q <= q & ~wdata;
        else if (load_we)
            q <= (q & ~load_mask) | (wdata & load_mask);
    end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bus_sel,
    input  logic  bus_wr,
    input  addr_t bus_addr,
    input  pins_t bus_wdata,
    input  pins_t pad_in,
    output pins_t bus_rdata,
    output cfg_t  cfg
);
    logic  wr_go, rd_go;
    pins_t trip_q [N_TRIP];
    pins_t dout_q;
    pins_t rd_next;

    assign wr_go = bus_sel & bus_wr;
    assign rd_go = bus_sel & ~bus_wr;

    for (genvar i = 0; i < N_TRIP; i++) begin : g_trip
        gpio_triplet #(.W(PIN_W), .RST_VAL(trip_rst(i))) u_reg (
            .clk      (clk),
            .rst      (rst),
            .set_we   (wr_go && bus_addr == trip_set_off(i)),
            .clr_we   (wr_go && bus_addr == trip_clr_off(i)),
            .load_we  (1'b0),
            .load_mask('0),
            .wdata    (bus_wdata),
            .q        (trip_q[i])
        );
    end

    gpio_triplet #(.W(PIN_W), .RST_VAL('0)) u_dout (
        .clk      (clk),
        .rst      (rst),
        .set_we   (wr_go && bus_addr == OFF_DSET),
        .clr_we   (wr_go && bus_addr == OFF_DCLR),
        .load_we  (wr_go && bus_addr == OFF_DSTAT),
        .load_mask(trip_q[T_OWE]),
        .wdata    (bus_wdata),
        .q        (dout_q)
    );

    assign cfg.own    = trip_q[T_OWN];
    assign cfg.oe     = trip_q[T_OE];
    assign cfg.filt   = trip_q[T_FILT];
    assign cfg.md     = trip_q[T_MD];
    assign cfg.pu_off = trip_q[T_PUOFF];
    assign cfg.selb   = trip_q[T_SELB];
    assign cfg.owe    = trip_q[T_OWE];
    assign cfg.dout   = dout_q;

    always_comb begin
        rd_next = '0;
        for (int i = 0; i < N_TRIP; i++)
            if (bus_addr == trip_stat_off(i))
                rd_next = trip_q[i];
        if (bus_addr == OFF_DSTAT)
            rd_next = dout_q;
        if (bus_addr == OFF_PIN)
            rd_next = pad_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (rd_go)
            bus_rdata <= rd_next;
    end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_pkg::*;
(
    input  cfg_t  cfg,
    input  pins_t pad_in,
    input  pins_t pa_oe,
    input  pins_t pa_out,
    input  pins_t pb_oe,
    input  pins_t pb_out,
    output pins_t pad_oe,
    output pins_t pad_out,
    output pins_t pa_din,
    output pins_t pb_din
);
    for (genvar p = 0; p < PIN_W; p++) begin : g_pin
        logic drv_oe, drv_out;
        always_comb begin
            if (cfg.own[p]) begin
                drv_oe  = cfg.oe[p];
                drv_out = cfg.dout[p];
            end else if (cfg.selb[p]) begin
                drv_oe  = pb_oe[p];
                drv_out = pb_out[p];
            end else begin
                drv_oe  = pa_oe[p];
                drv_out = pa_out[p];
            end
        end
        assign pad_oe[p]  = cfg.md[p] ? (drv_oe & ~drv_out) : drv_oe;
        assign pad_out[p] = drv_out;
        assign pa_din[p]  = ~cfg.own[p] & ~cfg.selb[p] & pad_in[p];
        assign pb_din[p]  = ~cfg.own[p] &  cfg.selb[p] & pad_in[p];
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bus_sel,
    input  logic  bus_wr,
    input  addr_t bus_addr,
    input  pins_t bus_wdata,
    output pins_t bus_rdata,
    input  pins_t pad_in,
    output pins_t pad_oe,
    output pins_t pad_out,
    output pins_t pad_pullup_n,
    output pins_t filt_en,
    input  pins_t pa_oe,
    input  pins_t pa_out,
    output pins_t pa_din,
    input  pins_t pb_oe,
    input  pins_t pb_out,
    output pins_t pb_din
);
    cfg_t cfg;

    gpio_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .pad_in   (pad_in),
        .bus_rdata(bus_rdata),
        .cfg      (cfg)
    );

    gpio_pinmux u_mux (
        .cfg    (cfg),
        .pad_in (pad_in),
        .pa_oe  (pa_oe),
        .pa_out (pa_out),
        .pb_oe  (pb_oe),
        .pb_out (pb_out),
        .pad_oe (pad_oe),
        .pad_out(pad_out),
        .pa_din (pa_din),
        .pb_din (pb_din)
    );

    assign pad_pullup_n = cfg.pu_off;
    assign filt_en      = cfg.filt;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  bus_sel,
    input logic  bus_wr,
    input addr_t bus_addr,
    input pins_t bus_wdata,
    input pins_t bus_rdata,
    input pins_t pad_in,
    input pins_t pad_oe,
    input pins_t pad_out,
    input pins_t pa_din,
    input pins_t pb_din,
    input cfg_t  cfg
);
    p_setclr_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 8'h00)
        |=> ((cfg.own & $past(bus_wdata)) == $past(bus_wdata)));

    p_rdlat_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == 8'h3C)
        |=> (bus_rdata == $past(pad_in)));

    p_din_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (((pa_din | pb_din) & cfg.own) == '0));

    p_din_excl_r6: assert property (@(posedge clk) disable iff (rst)
        ((pa_din & pb_din) == '0));

    p_dmask_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == 8'h38)
        |=> (((cfg.dout ^ $past(cfg.dout)) & ~$past(cfg.owe)) == '0));

    p_opendrain_r10: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & pad_out & cfg.md) == '0));
endmodule

bind gpio_bank gpio_bank_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .pa_din   (pa_din),
    .pb_din   (pb_din),
    .cfg      (cfg)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pad_in = '1, pad_oe, pad_out, pad_pullup_n, filt_en;
    logic [31:0] pa_oe = '0, pa_out = '0, pa_din, pb_oe = '0, pb_out = '0, pb_din;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pullup_n(pad_pullup_n), .filt_en(filt_en),
        .pa_oe(pa_oe), .pa_out(pa_out), .pa_din(pa_din),
        .pb_oe(pb_oe), .pb_out(pb_out), .pb_din(pb_din)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 own", 8'h08, 32'hFFFF_FFFF);
        rd_chk("R1 oe", 8'h18, 0);
        rd_chk("R1 filt", 8'h28, 0);
        rd_chk("R1 data", 8'h38, 0);
        rd_chk("R1 md", 8'h58, 0);
        rd_chk("R1 pu", 8'h68, 0);
        rd_chk("R1 ab", 8'h78, 0);
        rd_chk("R1 owe", 8'hA8, 0);
        check("R1 pad_oe", pad_oe, 0);
        check("R1 pullup_n", pad_pullup_n, 0);
    endtask

    task automatic t_setclr();
        wr(8'h10, 32'h0000_00F0);
        rd_chk("R2 oe set", 8'h18, 32'h0000_00F0);
        wr(8'h10, 32'h0000_000F);
        rd_chk("R2 oe set keep", 8'h18, 32'h0000_00FF);
        wr(8'h14, 32'h0000_0030);
        rd_chk("R2 oe clr", 8'h18, 32'h0000_00CF);
        check("R4 pad_oe", pad_oe, 32'h0000_00CF);
    endtask

    task automatic t_owned();
        wr(8'h30, 32'h0000_00A5);
        rd_chk("R4 data", 8'h38, 32'h0000_00A5);
        check("R4 pad_out", pad_out, 32'h0000_00A5);
        check("R4 pa_din", pa_din, 0);
        check("R4 pb_din", pb_din, 0);
    endtask

    task automatic t_rdzero();
        rd_chk("R3 wo 0x30", 8'h30, 0);
        rd_chk("R3 wo 0x00", 8'h00, 0);
        rd_chk("R3 unmapped", 8'h0C, 0);
    endtask

    task automatic t_periph();
        pa_oe = 32'h0000_FF00; pa_out = 32'h0000_3300;
        pb_oe = 32'hFFFF_0000; pb_out = 32'h1234_0000;
        wr(8'h04, 32'hFFFF_0000);
        check("R6 A pad_oe", pad_oe, 32'h0000_00CF);
        check("R6 A din", pa_din, 32'hFFFF_0000);
        wr(8'h74, 32'hFF00_0000);
        rd_chk("R6 ab stat", 8'h78, 32'hFF00_0000);
        check("R6 B pad_oe", pad_oe, 32'hFF00_00CF);
        check("R6 B pad_out", pad_out, 32'h1200_00A5);
        check("R6 pb_din", pb_din, 32'hFF00_0000);
        check("R6 pa_din", pa_din, 32'h00FF_0000);
        wr(8'h10, 32'h0001_0000);
        wr(8'h30, 32'h0001_0000);
        rd_chk("R5 oe stored", 8'h18, 32'h0001_00CF);
        rd_chk("R5 data stored", 8'h38, 32'h0001_00A5);
        check("R5 pad_oe held", pad_oe, 32'hFF00_00CF);
        check("R5 pad_out held", pad_out, 32'h1200_00A5);
        wr(8'h00, 32'h00FF_0000);
        check("R5 pad_oe back", pad_oe, 32'hFF01_00CF);
        check("R5 pad_out back", pad_out, 32'h1201_00A5);
        check("R4 pa_din back", pa_din, 0);
        wr(8'h70, 32'hFF00_0000);
        check("R6 A again", pad_oe, 32'h0001_00CF);
        check("R6 A again din", pa_din, 32'hFF00_0000);
    endtask

    task automatic t_direct();
        wr(8'hA0, 32'h0000_000F);
        rd_chk("R7 owe stat", 8'hA8, 32'h0000_000F);
        wr(8'h38, 32'h0000_000A);
        rd_chk("R7 masked", 8'h38, 32'h0001_00AA);
        wr(8'hA4, 32'h0000_000F);
        wr(8'h38, 32'h0000_0000);
        rd_chk("R7 no mask", 8'h38, 32'h0001_00AA);
    endtask

    task automatic t_pin();
        pad_in = 32'h5A5A_1234;
        rd_chk("R8 pin", 8'h3C, 32'h5A5A_1234);
        pad_in = 32'h0F0F_0F0F;
        rd_chk("R8 pin2", 8'h3C, 32'h0F0F_0F0F);
    endtask

    task automatic t_pull();
        wr(8'h60, 32'h0000_FFFF);
        rd_chk("R9 pu off", 8'h68, 32'h0000_FFFF);
        check("R9 pullup_n", pad_pullup_n, 32'h0000_FFFF);
        wr(8'h64, 32'h0000_00FF);
        rd_chk("R9 pu on", 8'h68, 32'h0000_FF00);
        check("R9 pullup_n2", pad_pullup_n, 32'h0000_FF00);
    endtask

    task automatic t_md();
        wr(8'h50, 32'h0000_00FF);
        rd_chk("R10 md stat", 8'h58, 32'h0000_00FF);
        check("R10 open drain", pad_oe, 32'h0001_0045);
        wr(8'h54, 32'h0000_00FF);
        check("R10 md off", pad_oe, 32'h0001_00CF);
    endtask

    task automatic t_filt();
        wr(8'h20, 32'h0000_0003);
        rd_chk("R11 filt stat", 8'h28, 32'h0000_0003);
        check("R11 filt_en", filt_en, 32'h0000_0003);
        wr(8'h24, 32'h0000_0001);
        check("R11 filt_en clr", filt_en, 32'h0000_0002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_setclr();
        t_owned();
        t_rdzero();
        t_periph();
        t_direct();
        t_pin();
        t_pull();
        t_md();
        t_filt();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule